// File: doc/BRIEF.md
# Register Sequence Command Executor

This block takes one fixed-size command of sixteen 32-bit words and carries it out as a series of accesses on a simple register bus. Word 0 is a header that gives an operation code and a payload length in bytes. Words 1 to 15 hold the payload. Four operations exist. A masked read-modify-write list updates up to five independent registers. A field-update chain applies up to seven mask/value steps to one register, keeping the running value inside the engine and reading the register at most once. A burst pushes up to fourteen data words to one address. A poll reads one register until a masked field matches, or until a limit in microseconds runs out.

A host hands over the whole command in one valid/ready transfer. Commands are taken only while the engine is idle. When the last bus transfer of a command is done, the engine pulses a completion strobe. A poll that runs out of time sets a sticky timeout flag and still completes the command. Operation codes the engine does not handle, and commands whose length gives zero items, complete at once with no bus traffic.

Top module: `regseq_engine`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `bus_req`, `cmd_done` and `wait_timeout` are 0.
- R2: A command is taken only on a clock edge where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` is 1 only when no command is in progress. While a command is running, `cmd_valid` is ignored and causes no bus traffic.
- R3: The operation code is header bits 7:0 and the payload byte count is header bits 29:24. Header bits 23:8 and 31:30 have no effect.
- R4: Code 1 (read-modify-write) runs min(bytes/12, 5) items. Item i uses word 1+3i as the address, word 2+3i as the mask and word 3+3i as the value. For each item the engine reads the address, then writes (old & ~mask) | (value & mask) to it.
- R5: In a read-modify-write item whose mask is all ones, the read is skipped and the value is written directly.
- R6: Code 2 (field update) targets the address in word 1 and runs min((bytes-4)/8, 7) steps, or none if bytes < 4. Step j uses mask word 2+2j and value word 3+2j. The register is read once, before step 0, and only if the step-0 mask is not all ones; otherwise the running value starts at 0. Each step merges its mask/value into the running value and writes the result, with no read in between.
- R7: Code 3 (burst) writes words 2, 3, ... in order to the address in word 1. The number of writes is min((bytes-4)/4, 14), or none if bytes < 4.
- R8: Code 4 (poll) reads the address in word 1 again and again. It completes as soon as (read data & word 2) equals word 3. It never writes.
- R9: A poll that has not matched once its elapsed microsecond count (one per TICK_DIV clocks) reaches the limit in word 4 sets `wait_timeout` and completes after the read in progress. `wait_timeout` then stays 1 until reset. With limit 0 and no match, the poll completes after one read.
- R10: Codes other than 1 to 4, and commands that yield zero items, complete within two clocks of acceptance with no bus transfer.
- R11: `cmd_done` is a one-cycle pulse in the cycle after the last bus transfer. In the next cycle `cmd_ready` is 1 again.
- R12: Once `bus_req` is raised, it stays 1 and `bus_we`, `bus_addr` and `bus_wdata` hold until a cycle with `bus_ready` high. Each such cycle completes exactly one transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle and able to take a command |
| cmd_data | input | 512 | Command words; word k is bits 32k+31:32k, word 0 is the header |
| cmd_done | output | 1 | One-cycle pulse when a command finishes |
| wait_timeout | output | 1 | Sticky flag: a poll ran out of time |
| bus_req | output | 1 | Register bus request |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_addr | output | 32 | Register address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid in the cycle `bus_ready` is high |
| bus_ready | input | 1 | Completes the pending transfer this cycle |

## Verification
The assertions assume a bus responder that raises `bus_ready` only while `bus_req` is high and returns read data in that same cycle. They also assume that reset is held low from time zero. The bench's responder drives `bus_ready` and `bus_rdata` at the falling edge, only while a request is pending, with a random wait of zero to two cycles. Randomised addresses stay out of the one register reserved for poll tests, whose read value counts up. The bench pokes `cmd_valid` during a running burst only to confirm that it is ignored. Random commands never use the poll code, so the timeout flag stays clear until the directed poll tests at the end.

// File: rtl/regseq_pkg.sv
// Package: shared operation and state types for the register sequence engine.
// Assumes: header operation codes are 8 bits wide.
package regseq_pkg;

    // Header operation codes (fixed by the command format)
    localparam logic [7:0] CODE_RMW   = 8'd1;
    localparam logic [7:0] CODE_FIELD = 8'd2;
    localparam logic [7:0] CODE_BURST = 8'd3;
    localparam logic [7:0] CODE_POLL  = 8'd4;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_RMW,
        OP_FIELD,
        OP_BURST,
        OP_POLL
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_READ,
        ST_WRITE,
        ST_DONE
    } seq_state_e;

endpackage

// File: rtl/regseq_tick.sv
// Module: free-running prescaler that gives a one-cycle pulse every TICK_DIV clocks.
// Assumes: TICK_DIV >= 1; with TICK_DIV = 1 the pulse is high every cycle.
module regseq_tick #(
    parameter int TICK_DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    logic [PW-1:0] cnt;

    // Count clocks and wrap after the last one of each microsecond
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);

    generate
        if (TICK_DIV > 1) begin : g_gap_check
            // Ticks are never back to back when the divider exceeds one
            assert_tick_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/regseq_decode.sv
// Module: splits the stored command into words and, for the current item index,
// gives the operation, item count, address, mask, value and poll limit.
// Assumes: word 0 is the header; item index is below the count when used.
module regseq_decode
    import regseq_pkg::*;
#(
    parameter int DW        = 32,
    parameter int CMD_WORDS = 16,
    localparam int CNT_W    = $clog2(CMD_WORDS)
) (
    input  logic [CMD_WORDS*DW-1:0] cmd_bits,
    input  logic [CNT_W-1:0]        item_idx,
    output op_e                     op,
    output logic [CNT_W-1:0]        item_count,
    output logic [DW-1:0]           item_addr,
    output logic [DW-1:0]           item_mask,
    output logic [DW-1:0]           item_val,
    output logic [DW-1:0]           poll_limit
);
    localparam int RMW_MAX   = (CMD_WORDS - 1) / 3;
    localparam int FIELD_MAX = (CMD_WORDS - 2) / 2;
    localparam int BURST_MAX = CMD_WORDS - 2;

    logic [DW-1:0] words [CMD_WORDS];
    logic [DW-1:0] hdr;
    logic [7:0]    code;
    logic [5:0]    nbytes;
    logic          unused_hdr;

    genvar g;
    generate
        for (g = 0; g < CMD_WORDS; g++) begin : g_unpack
            assign words[g] = cmd_bits[g*DW +: DW];
        end
    endgenerate

    assign hdr        = words[0];
    assign code       = hdr[7:0];
    assign nbytes     = hdr[29:24];
    assign unused_hdr = &{1'b0, hdr[23:8], hdr[31:30]};

    // Word fetch with a guard for indices past the command
    function automatic logic [DW-1:0] pick(input int k);
        if (k >= 0 && k < CMD_WORDS) pick = words[k[CNT_W-1:0]];
        else                         pick = '0;
    endfunction

    // Item count for an operation from the payload byte count, clamped
    function automatic logic [CNT_W-1:0] count_of(input op_e o, input logic [5:0] b);
        int n;
        int bi;
        bi = int'(b);
        case (o)
            OP_RMW:   n = bi / 12;
            OP_FIELD: n = (bi >= 4) ? (bi - 4) / 8 : 0;
            OP_BURST: n = (bi >= 4) ? (bi - 4) / 4 : 0;
            OP_POLL:  n = 1;
            default:  n = 0;
        endcase
        if (o == OP_RMW   && n > RMW_MAX)   n = RMW_MAX;
        if (o == OP_FIELD && n > FIELD_MAX) n = FIELD_MAX;
        if (o == OP_BURST && n > BURST_MAX) n = BURST_MAX;
        count_of = CNT_W'(n);
    endfunction

    // Map the header code onto an operation
    always_comb begin
        case (code)
            CODE_RMW:   op = OP_RMW;
            CODE_FIELD: op = OP_FIELD;
            CODE_BURST: op = OP_BURST;
            CODE_POLL:  op = OP_POLL;
            default:    op = OP_NONE;
        endcase
    end

    assign item_count = count_of(op, nbytes);

    // Select the address, mask and value words for the current item
    always_comb begin
        int i;
        i          = int'(item_idx);
        item_addr  = '0;
        item_mask  = '0;
        item_val   = '0;
        poll_limit = '0;
        case (op)
            OP_RMW: begin
                item_addr = pick(1 + 3 * i);
                item_mask = pick(2 + 3 * i);
                item_val  = pick(3 + 3 * i);
            end
            OP_FIELD: begin
                item_addr = pick(1);
                item_mask = pick(2 + 2 * i);
                item_val  = pick(3 + 2 * i);
            end
            OP_BURST: begin
                item_addr = pick(1);
                item_mask = '1;
                item_val  = pick(2 + i);
            end
            OP_POLL: begin
                item_addr  = pick(1);
                item_mask  = pick(2);
                item_val   = pick(3);
                poll_limit = pick(4);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/regseq_sequencer.sv
// Module: holds the accepted command and steps through its items, issuing reads
// and writes on the register bus, tracking the running value and poll time.
// Assumes: bus_ready is only raised while bus_req is high and read data is
// valid in that cycle; decode outputs depend only on cmd_q and item_idx.
module regseq_sequencer
    import regseq_pkg::*;
#(
    parameter int DW        = 32,
    parameter int CMD_WORDS = 16,
    localparam int CNT_W    = $clog2(CMD_WORDS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    output logic                    cmd_ready,
    input  logic [CMD_WORDS*DW-1:0] cmd_bits,
    output logic [CMD_WORDS*DW-1:0] cmd_q,
    output logic [CNT_W-1:0]        item_idx,
    input  op_e                     op_i,
    input  logic [CNT_W-1:0]        item_count,
    input  logic [DW-1:0]           item_addr,
    input  logic [DW-1:0]           item_mask,
    input  logic [DW-1:0]           item_val,
    input  logic [DW-1:0]           poll_limit,
    input  logic                    us_tick,
    output logic                    bus_req,
    output logic                    bus_we,
    output logic [DW-1:0]           bus_addr,
    output logic [DW-1:0]           bus_wdata,
    input  logic [DW-1:0]           bus_rdata,
    input  logic                    bus_ready,
    output logic                    cmd_done,
    output logic                    wait_timeout
);
    seq_state_e    state;
    logic [DW-1:0] work;
    logic [DW-1:0] us_cnt;
    logic          timeout_q;
    logic          last_item;
    logic          poll_hit;

    // Replace the masked bits of a base word with those of a value
    function automatic logic [DW-1:0] merge(input logic [DW-1:0] base,
                                            input logic [DW-1:0] m,
                                            input logic [DW-1:0] v);
        merge = (base & ~m) | (v & m);
    endfunction

    assign last_item = (item_idx == item_count - 1'b1);
    assign poll_hit  = ((bus_rdata & item_mask) == item_val);

    // Main item sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cmd_q    <= '0;
            item_idx <= '0;
            work     <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        cmd_q    <= cmd_bits;
                        item_idx <= '0;
                        state    <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (op_i == OP_NONE || item_count == '0) begin
                        state <= ST_DONE;
                    end else begin
                        case (op_i)
                            OP_RMW: begin
                                if (item_mask == '1) begin
                                    work  <= item_val;
                                    state <= ST_WRITE;
                                end else begin
                                    state <= ST_READ;
                                end
                            end
                            OP_FIELD: begin
                                if (item_idx == '0 && item_mask != '1) begin
                                    state <= ST_READ;
                                end else begin
                                    work  <= merge((item_idx == '0) ? '0 : work, item_mask, item_val);
                                    state <= ST_WRITE;
                                end
                            end
                            OP_BURST: begin
                                work  <= item_val;
                                state <= ST_WRITE;
                            end
                            default: state <= ST_READ;
                        endcase
                    end
                end
                ST_READ: begin
                    if (bus_ready) begin
                        if (op_i == OP_POLL) begin
                            if (poll_hit || us_cnt >= poll_limit) state <= ST_DONE;
                        end else begin
                            work  <= merge(bus_rdata, item_mask, item_val);
                            state <= ST_WRITE;
                        end
                    end
                end
                ST_WRITE: begin
                    if (bus_ready) begin
                        if (last_item) begin
                            state <= ST_DONE;
                        end else begin
                            item_idx <= item_idx + 1'b1;
                            state    <= ST_LOAD;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Elapsed microseconds of the current poll, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)                         us_cnt <= '0;
        else if (state == ST_LOAD)          us_cnt <= '0;
        else if (us_tick && us_cnt != '1)   us_cnt <= us_cnt + 1'b1;
    end

    // Sticky flag for a poll that ended without a match
    always_ff @(posedge clk) begin
        if (!rst_n)
            timeout_q <= 1'b0;
        else if (state == ST_READ && op_i == OP_POLL && bus_ready && !poll_hit && us_cnt >= poll_limit)
            timeout_q <= 1'b1;
    end

    assign cmd_ready    = (state == ST_IDLE);
    assign bus_req      = (state == ST_READ) || (state == ST_WRITE);
    assign bus_we       = (state == ST_WRITE);
    assign bus_addr     = item_addr;
    assign bus_wdata    = work;
    assign cmd_done     = (state == ST_DONE);
    assign wait_timeout = timeout_q;

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ready |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !bus_req);

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done && cmd_ready);

    assert_timeout_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wait_timeout |=> wait_timeout);

    assert_poll_readonly_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && op_i == OP_POLL |-> !bus_we);

    assert_field_one_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_we && op_i == OP_FIELD |-> item_idx == '0);

    assert_null_quick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_LOAD && op_i == OP_NONE |=> cmd_done);

endmodule

// File: rtl/regseq_engine.sv
// Module: top of the register sequence engine; joins the command sequencer,
// the item decoder and the microsecond prescaler.
// Assumes: TICK_DIV clock cycles make one microsecond.
module regseq_engine
    import regseq_pkg::*;
#(
    parameter int DW        = 32,
    parameter int CMD_WORDS = 16,
    parameter int TICK_DIV  = 50
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    output logic                    cmd_ready,
    input  logic [CMD_WORDS*DW-1:0] cmd_data,
    output logic                    cmd_done,
    output logic                    wait_timeout,
    output logic                    bus_req,
    output logic                    bus_we,
    output logic [DW-1:0]           bus_addr,
    output logic [DW-1:0]           bus_wdata,
    input  logic [DW-1:0]           bus_rdata,
    input  logic                    bus_ready
);
    localparam int CNT_W = $clog2(CMD_WORDS);

    logic [CMD_WORDS*DW-1:0] cmd_q;
    logic [CNT_W-1:0]        item_idx;
    logic [CNT_W-1:0]        item_count;
    op_e                     op;
    logic [DW-1:0]           item_addr;
    logic [DW-1:0]           item_mask;
    logic [DW-1:0]           item_val;
    logic [DW-1:0]           poll_limit;
    logic                    us_tick;

    regseq_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (us_tick)
    );

    regseq_decode #(.DW(DW), .CMD_WORDS(CMD_WORDS)) u_decode (
        .cmd_bits   (cmd_q),
        .item_idx   (item_idx),
        .op         (op),
        .item_count (item_count),
        .item_addr  (item_addr),
        .item_mask  (item_mask),
        .item_val   (item_val),
        .poll_limit (poll_limit)
    );

    regseq_sequencer #(.DW(DW), .CMD_WORDS(CMD_WORDS)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_ready    (cmd_ready),
        .cmd_bits     (cmd_data),
        .cmd_q        (cmd_q),
        .item_idx     (item_idx),
        .op_i         (op),
        .item_count   (item_count),
        .item_addr    (item_addr),
        .item_mask    (item_mask),
        .item_val     (item_val),
        .poll_limit   (poll_limit),
        .us_tick      (us_tick),
        .bus_req      (bus_req),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .bus_ready    (bus_ready),
        .cmd_done     (cmd_done),
        .wait_timeout (wait_timeout)
    );

endmodule

// File: tb/tb_regseq_engine.sv
module tb_regseq_engine;
    localparam int DW  = 32;
    localparam int CW  = 16;
    localparam int DIV = 20;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cmd_valid = 1'b0;
    logic            cmd_ready;
    logic [CW*DW-1:0] cmd_data = '0;
    logic            cmd_done;
    logic            wait_timeout;
    logic            bus_req;
    logic            bus_we;
    logic [DW-1:0]   bus_addr;
    logic [DW-1:0]   bus_wdata;
    logic [DW-1:0]   bus_rdata = '0;
    logic            bus_ready = 1'b0;

    always #10 clk = ~clk;

    regseq_engine #(.DW(DW), .CMD_WORDS(CW), .TICK_DIV(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_data(cmd_data), .cmd_done(cmd_done), .wait_timeout(wait_timeout),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready)
    );

    int checks = 0;
    int fails  = 0;

    // Bench register file (register 15 is the counting poll register)
    logic [31:0] bmem [16];
    logic [31:0] mmem [16];
    int          poll_ctr = 0;
    int          lat = 0;

    logic        log_we   [64];
    logic [31:0] log_addr [64];
    logic [31:0] log_data [64];
    int          log_n = 0, reads_n = 0, writes_n = 0;

    logic        exp_we   [64];
    logic [31:0] exp_addr [64];
    logic [31:0] exp_data [64];
    int          exp_n = 0;

    logic [31:0] cw [16];
    int  busy_bad = 0;
    bit  done_seen, pulse_ok;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Bus responder: answers at the falling edge with 0..2 wait cycles
    always @(negedge clk) begin
        if (!rst_n) begin
            bus_ready = 1'b0;
            lat = 0;
        end else if (bus_req) begin
            if (lat == 0) begin
                automatic int ix = int'(bus_addr[5:2]);
                bus_ready = 1'b1;
                if (bus_we) begin
                    bmem[ix] = bus_wdata;
                    writes_n++;
                end else begin
                    if (ix == 15) begin
                        bus_rdata = 32'(poll_ctr);
                        poll_ctr++;
                    end else begin
                        bus_rdata = bmem[ix];
                    end
                    reads_n++;
                end
                if (log_n < 64) begin
                    log_we[log_n]   = bus_we;
                    log_addr[log_n] = bus_addr;
                    log_data[log_n] = bus_wdata;
                end
                log_n++;
                lat = $urandom_range(0, 2);
            end else begin
                bus_ready = 1'b0;
                lat--;
            end
        end else begin
            bus_ready = 1'b0;
        end
    end

    function automatic logic [31:0] mrg(input logic [31:0] b, input logic [31:0] m, input logic [31:0] v);
        return (b & ~m) | (v & m);
    endfunction

    task automatic exp_push(input logic we, input logic [31:0] a, input logic [31:0] d);
        exp_we[exp_n] = we; exp_addr[exp_n] = a; exp_data[exp_n] = d; exp_n++;
    endtask

    // Expected bus trace and register contents from the requirements
    task automatic model_cmd();
        automatic int code  = int'(cw[0][7:0]);
        automatic int bytes = int'(cw[0][29:24]);
        automatic int n;
        automatic logic [31:0] run;
        exp_n = 0;
        if (code == 1) begin
            n = bytes / 12; if (n > 5) n = 5;
            for (int i = 0; i < n; i++) begin
                automatic logic [31:0] a = cw[1+3*i];
                automatic logic [31:0] base = 32'h0;
                if (cw[2+3*i] != 32'hFFFF_FFFF) begin
                    exp_push(1'b0, a, 32'h0);
                    base = mmem[a[5:2]];
                end
                run = mrg(base, cw[2+3*i], cw[3+3*i]);
                exp_push(1'b1, a, run);
                mmem[a[5:2]] = run;
            end
        end else if (code == 2) begin
            n = (bytes >= 4) ? (bytes - 4) / 8 : 0; if (n > 7) n = 7;
            run = 32'h0;
            if (n > 0 && cw[2] != 32'hFFFF_FFFF) begin
                exp_push(1'b0, cw[1], 32'h0);
                run = mmem[cw[1][5:2]];
            end
            for (int j = 0; j < n; j++) begin
                run = mrg(run, cw[2+2*j], cw[3+2*j]);
                exp_push(1'b1, cw[1], run);
                mmem[cw[1][5:2]] = run;
            end
        end else if (code == 3) begin
            n = (bytes >= 4) ? (bytes - 4) / 4 : 0; if (n > 14) n = 14;
            for (int j = 0; j < n; j++) begin
                exp_push(1'b1, cw[1], cw[2+j]);
                mmem[cw[1][5:2]] = cw[2+j];
            end
        end
    endtask

    task automatic check_trace(input string req);
        automatic bit ok = (log_n == exp_n);
        automatic int bad = -1;
        for (int i = 0; i < exp_n && ok; i++) begin
            if (log_we[i] != exp_we[i] || log_addr[i] != exp_addr[i] ||
                (exp_we[i] && log_data[i] != exp_data[i])) begin
                ok = 1'b0; bad = i;
            end
        end
        if (bad < 0) check(ok, req, 32'(log_n), 32'(exp_n));
        else         check(ok, req, log_data[bad], exp_data[bad]);
    endtask

    // Offer one command, optionally poke cmd_valid while busy, wait for done
    task automatic run_cmd(input bit poke, output int cyc);
        log_n = 0; reads_n = 0; writes_n = 0;
        @(negedge clk);
        for (int k = 0; k < CW; k++) cmd_data[k*DW +: DW] = cw[k];
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        cyc = 0;
        while (!cmd_done && cyc < 20000) begin
            if (poke && cyc < 4) begin
                cmd_data[31:0] = 32'h0C00_0001;
                cmd_valid = 1'b1;
                if (cmd_ready) busy_bad++;
            end else begin
                cmd_valid = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        cmd_valid = 1'b0;
        done_seen = cmd_done;
        @(negedge clk);
        pulse_ok = !cmd_done && cmd_ready;
    endtask

    function automatic logic [31:0] rand_addr();
        return {$urandom_range(0, 32'h03FF_FFFF), 4'($urandom_range(0, 14)), 2'b00};
    endfunction

    function automatic logic [31:0] rand_mask();
        automatic int r = $urandom_range(0, 3);
        if (r == 0) return 32'hFFFF_FFFF;
        if (r == 1) return 32'h0000_00FF;
        return $urandom;
    endfunction

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        automatic int cyc;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) begin
            automatic logic [31:0] v = $urandom;
            bmem[i] = v; mmem[i] = v;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd_ready && !bus_req && !cmd_done && !wait_timeout, "R1 reset state",
              {cmd_ready, bus_req, cmd_done, wait_timeout}, 32'h8);

        // R5: read-modify-write, second item mask all ones (no read)
        for (int k = 0; k < 16; k++) cw[k] = $urandom;
        cw[0] = {2'b00, 6'd24, 16'h0000, 8'd1};
        cw[1] = 32'h0000_0004; cw[2] = 32'h0000_FF00;
        cw[4] = 32'h0000_0008; cw[5] = 32'hFFFF_FFFF;
        model_cmd(); run_cmd(1'b0, cyc);
        check_trace("R4 R5 rmw two items");
        check(reads_n == 1, "R5 skipped read", 32'(reads_n), 32'd1);
        check(done_seen && pulse_ok, "R11 done pulse", {30'h0, done_seen, pulse_ok}, 32'h3);

        // R6: field update, first mask all ones -> no read, three steps
        for (int k = 0; k < 16; k++) cw[k] = $urandom;
        cw[0] = {2'b00, 6'd28, 16'h0000, 8'd2};
        cw[1] = 32'h0000_0010; cw[2] = 32'hFFFF_FFFF;
        model_cmd(); run_cmd(1'b0, cyc);
        check_trace("R6 field chain no read");
        check(reads_n == 0 && writes_n == 3, "R6 read-free counts", 32'(reads_n * 16 + writes_n), 32'd3);

        // R6: field update, seven steps with one initial read
        for (int k = 0; k < 16; k++) cw[k] = $urandom;
        cw[0] = {2'b00, 6'd60, 16'h0000, 8'd2};
        cw[1] = 32'h0000_0014; cw[2] = 32'h0000_000F;
        model_cmd(); run_cmd(1'b0, cyc);
        check_trace("R6 field chain seven steps");
        check(reads_n == 1 && writes_n == 7, "R6 one read seven writes", 32'(reads_n * 16 + writes_n), 32'd23);

        // R7 and R2: full burst while cmd_valid is poked during execution
        for (int k = 0; k < 16; k++) cw[k] = $urandom;
        cw[0] = {2'b00, 6'd60, 16'h0000, 8'd3};
        cw[1] = 32'h0000_0020;
        busy_bad = 0;
        model_cmd(); run_cmd(1'b1, cyc);
        check_trace("R7 burst of fourteen");
        check(busy_bad == 0, "R2 not ready while busy", 32'(busy_bad), 32'd0);
        log_n = 0;
        repeat (6) @(negedge clk);
        check(log_n == 0 && !bus_req && cmd_ready, "R2 poke ignored", 32'(log_n), 32'd0);

        // R3: noise in ignored header bits
        for (int k = 0; k < 16; k++) cw[k] = $urandom;
        cw[0] = {2'b11, 6'd12, 16'hFFFF, 8'd3};
        cw[1] = 32'h0000_0024;
        model_cmd(); run_cmd(1'b0, cyc);
        check_trace("R3 ignored header bits");

        // R10: null, unknown code, and zero-item commands
        cw[0] = {2'b00, 6'd60, 16'h0000, 8'd0};
        run_cmd(1'b0, cyc);
        check(log_n == 0 && cyc <= 1, "R10 null code", 32'(log_n * 256 + cyc), 32'd1);
        cw[0] = {2'b00, 6'd60, 16'h0000, 8'd66};
        run_cmd(1'b0, cyc);
        check(log_n == 0 && cyc <= 1, "R10 unknown code", 32'(log_n * 256 + cyc), 32'd1);
        cw[0] = {2'b00, 6'd11, 16'h0000, 8'd1};
        run_cmd(1'b0, cyc);
        check(log_n == 0 && cyc <= 1, "R10 zero items", 32'(log_n * 256 + cyc), 32'd1);

        // Random mix of operations (R4 R6 R7 R12)
        for (int t = 0; t < 60; t++) begin
            automatic int sel = $urandom_range(0, 9);
            automatic logic [7:0] code;
            code = (sel < 3) ? 8'd1 : (sel < 6) ? 8'd2 : (sel < 8) ? 8'd3 : (sel == 8) ? 8'd0 : 8'd7;
            for (int k = 1; k < 16; k++) cw[k] = $urandom;
            cw[0] = {2'($urandom), 6'($urandom_range(0, 63)), 16'($urandom), code};
            if (code == 8'd1) begin
                for (int i = 0; i < 5; i++) begin
                    cw[1+3*i] = rand_addr(); cw[2+3*i] = rand_mask();
                end
            end else begin
                cw[1] = rand_addr();
                if (code == 8'd2) for (int j = 0; j < 7; j++) cw[2+2*j] = rand_mask();
            end
            model_cmd(); run_cmd(1'b0, cyc);
            check_trace($sformatf("R4 R6 R7 R12 random cmd %0d code %0d", t, code));
        end
        begin
            automatic int mism = 0;
            for (int i = 0; i < 15; i++) if (bmem[i] != mmem[i]) mism++;
            check(mism == 0, "R4 register contents", 32'(mism), 32'd0);
        end

        // R8: poll until counting register matches
        poll_ctr = 0;
        cw[0] = {2'b00, 6'd16, 16'h0000, 8'd4};
        cw[1] = 32'h0000_003C; cw[2] = 32'h0000_00FF; cw[3] = 32'd5; cw[4] = 32'd1000;
        run_cmd(1'b0, cyc);
        check(reads_n == 6 && writes_n == 0, "R8 poll reads", 32'(reads_n * 16 + writes_n), 32'd96);
        check(!wait_timeout, "R8 no timeout on match", {31'h0, wait_timeout}, 32'h0);

        // R9: poll that never matches, limit 3 microseconds
        cw[2] = 32'h8000_0000; cw[3] = 32'h8000_0000; cw[4] = 32'd3;
        run_cmd(1'b0, cyc);
        check(wait_timeout && writes_n == 0, "R9 timeout flag", {31'h0, wait_timeout}, 32'h1);
        check(cyc >= 2 * DIV && cyc <= 3 * DIV + 8, "R9 timeout duration", 32'(cyc), 32'(3 * DIV));

        // R9: zero limit ends after one read
        cw[4] = 32'd0;
        run_cmd(1'b0, cyc);
        check(reads_n == 1 && done_seen, "R9 zero limit", 32'(reads_n), 32'd1);

        // R9: flag stays set across a later command
        for (int k = 0; k < 16; k++) cw[k] = $urandom;
        cw[0] = {2'b00, 6'd8, 16'h0000, 8'd3};
        cw[1] = 32'h0000_0030;
        model_cmd(); run_cmd(1'b0, cyc);
        check_trace("R7 short burst");
        check(wait_timeout, "R9 sticky flag", {31'h0, wait_timeout}, 32'h1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule